// File: doc/BRIEF.md
# Camera Byte Stream Format Converter

This block sits behind a camera capture path and reshapes a stream of 8-bit sensor bytes. A two-bit configuration input picks one of four modes. In raw mode each byte is sent on unchanged. In interleaved 4:2:2 mode the bytes are sorted into a brightness stream and a colour-difference stream. In the two packed-RGB modes each pair of bytes is joined into one pixel, and the pixel is turned into studio-range Y, Cb and Cr.

All results leave on one 8-bit data bus. Two valid strobes go with it: one marks brightness samples and one marks colour samples, so a consumer can pick either stream off the shared bus. A start-of-line input realigns the byte counter that tracks where each byte sits inside its group. A second configuration bit turns the 4:2:2 split on or off. Every path has the same pipeline depth, so a mode change needs nothing more than a short idle gap.

Top module: `pix_fmt_conv`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_luma_vld` and `out_chroma_vld` are low and `out_data` is 0.
- R2: `out_luma_vld` and `out_chroma_vld` are never high in the same cycle.
- R3: Mode 1 (`cfg_mode`=2'b01) with `cfg_split`=1 treats each byte group as luma, Cb, luma, Cr (byte phases 0 to 3). A byte at phase 0 or 2 comes out unchanged with `out_luma_vld`. A byte at phase 1 or 3 comes out unchanged with `out_chroma_vld`. Each appears 3 cycles after its input cycle.
- R4: A valid byte presented with `in_sol`=1 is always taken as phase 0, in every mode. The phase then advances by one per valid byte, modulo 4, whatever the previous phase was.
- R5: Mode 1 with `cfg_split`=0 sends every byte unchanged with only `out_luma_vld`, 3 cycles after input.
- R6: Mode 0 (`cfg_mode`=2'b00) sends every byte unchanged with only `out_luma_vld`, 3 cycles after input.
- R7: Mode 2 (`cfg_mode`=2'b10) reads the byte at an even phase as the high byte and the next byte as the low byte of a 16-bit word: R=word[15:11], G=word[10:5], B=word[4:0]. Each field is widened to 8 bits by appending its own most significant bits below it.
- R8: Mode 3 (`cfg_mode`=2'b11) reads the same byte pair as R=high[3:0], G=low[7:4], B=low[3:0]. Each field is widened to 8 bits as v*17. High[7:4] is ignored.
- R9: Using integer floor division, Y = ((66R+129G+25B+128)>>8)+16, Cb = ((-38R-74G+112B+128)>>8)+128 and Cr = ((112R-94G-18B+128)>>8)+128. Each result is then clamped to 0..255.
- R10: In modes 2 and 3, Y appears with `out_luma_vld` 3 cycles after the cycle of the low byte. A chroma value follows in the next cycle with `out_chroma_vld`. It is Cb when the low byte sits at phase 1 and Cr when it sits at phase 3. Idle cycles between the two bytes of a pixel are allowed.
- R11: A cycle with `in_valid`=0 produces no strobe on its own, so both strobes stay low 3 cycles after an idle input cycle (and 4 cycles after, where no RGB chroma is due).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 raw, 1 interleaved 4:2:2, 2 RGB 5-6-5, 3 RGB 4-4-4 |
| cfg_split | input | 1 | Enables the luma/chroma split in mode 1 |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_sol | input | 1 | Marks the first byte of a line |
| in_byte | input | PIX_W | Sensor byte |
| out_data | output | PIX_W | Shared result bus, 0 when no strobe is high |
| out_luma_vld | output | 1 | Marks a brightness (or raw) sample on `out_data` |
| out_chroma_vld | output | 1 | Marks a colour-difference sample on `out_data` |

## Verification
Byte results in every mode are due exactly 3 cycles after their input cycle. RGB luma is due 3 cycles after the low byte, and its chroma companion 4 cycles after. The bench keeps its own cycle count and, for each input byte, writes the expected strobe pair and data into a small ring indexed by the due cycle. On every falling edge it compares the outputs against the slot for that cycle, so idle slots are checked as quiet. The RGB modes are swept over every 16-bit and every 12-bit pixel word, with inserted stalls and line restarts.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   typedef enum logic [1:0] {
      PFC_RAW    = 2'b00,
      PFC_YC422  = 2'b01,
      PFC_RGB565 = 2'b10,
      PFC_RGB444 = 2'b11
   } pfc_mode_e;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } pfc_rgb_t;

   localparam int PFC_FRAC  = 8;
   localparam int PFC_ROUND = 1 << (PFC_FRAC - 1);
   localparam int PFC_COEF [3][3] = '{'{66, 129, 25},
                                      '{-38, -74, 112},
                                      '{112, -94, -18}};
   localparam int PFC_OFFS [3] = '{16, 128, 128};

   // widen an nb-bit field held in the low bits of v to 8 bits by repeating its top bits
   function automatic logic [7:0] pfc_widen(input logic [7:0] v, input int nb);
      logic [7:0] o;
      for (int i = 0; i < 8; i++) begin
         o[7-i] = v[nb - 1 - (i % nb)];
      end
      return o;
   endfunction

   function automatic logic [7:0] pfc_clamp8(input int x);
      logic [7:0] o;
      if (x < 0)        o = 8'd0;
      else if (x > 255) o = 8'd255;
      else              o = x[7:0];
      return o;
   endfunction

endpackage

// File: rtl/pfc_byte_phase.sv
module pfc_byte_phase
   import pfc_pkg::*;
#(
   parameter int GROUP = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_sol,
   output logic [$clog2(GROUP)-1:0]   cur_phase
);
   localparam int PH_W = $clog2(GROUP);

   if ((1 << PH_W) != GROUP) begin : g_bad_group
      $error("pfc_byte_phase: GROUP must be a power of two");
   end

   logic [PH_W-1:0] phase_q;

   assign cur_phase = in_sol ? '0 : phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        phase_q <= '0;
      else if (in_valid) phase_q <= cur_phase + 1'b1;
   end

   // R4: a start-of-line byte is phase 0, so the next byte is phase 1
   p_sol_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sol) |=> (phase_q == PH_W'(1)));

endmodule

// File: rtl/pfc_rgb_unpack.sv
module pfc_rgb_unpack
   import pfc_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_we,
   input  logic [PIX_W-1:0] in_byte,
   input  logic             is_444,
   output pfc_rgb_t         rgb
);
   localparam int WORD_W = 2 * PIX_W;

   logic [PIX_W-1:0]  hi_q;
   logic [WORD_W-1:0] word;
   pfc_rgb_t          rgb565, rgb444;

   always_ff @(posedge clk) begin
      if (!rst_n)     hi_q <= '0;
      else if (hi_we) hi_q <= in_byte;
   end

   assign word = {hi_q, in_byte};

   always_comb begin
      rgb565.r = pfc_widen({3'b000, word[15:11]}, 5);
      rgb565.g = pfc_widen({2'b00,  word[10:5]},  6);
      rgb565.b = pfc_widen({3'b000, word[4:0]},   5);
      rgb444.r = pfc_widen({4'b0000, word[11:8]}, 4);
      rgb444.g = pfc_widen({4'b0000, word[7:4]},  4);
      rgb444.b = pfc_widen({4'b0000, word[3:0]},  4);
      rgb      = is_444 ? rgb444 : rgb565;
   end

endmodule

// File: rtl/pfc_csc.sv
module pfc_csc
   import pfc_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  pfc_rgb_t         in_rgb,
   input  logic             in_cr,
   output logic             out_vld,
   output logic [PIX_W-1:0] out_y,
   output logic [PIX_W-1:0] out_c
);
   localparam int SUM_W = 2 * PIX_W + 2;

   logic signed [SUM_W-1:0] sum_q [3];
   logic                    vld_q, cr_q;

   for (genvar ch = 0; ch < 3; ch++) begin : g_row
      int acc;
      always_comb begin
         acc = PFC_COEF[ch][0] * int'(in_rgb.r)
             + PFC_COEF[ch][1] * int'(in_rgb.g)
             + PFC_COEF[ch][2] * int'(in_rgb.b)
             + PFC_ROUND;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) sum_q[ch] <= '0;
         else        sum_q[ch] <= acc[SUM_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         cr_q    <= 1'b0;
         out_vld <= 1'b0;
         out_y   <= '0;
         out_c   <= '0;
      end else begin
         vld_q   <= in_vld;
         cr_q    <= in_cr;
         out_vld <= vld_q;
         out_y   <= pfc_clamp8((int'(sum_q[0]) >>> PFC_FRAC) + PFC_OFFS[0]);
         out_c   <= cr_q ? pfc_clamp8((int'(sum_q[2]) >>> PFC_FRAC) + PFC_OFFS[2])
                         : pfc_clamp8((int'(sum_q[1]) >>> PFC_FRAC) + PFC_OFFS[1]);
      end
   end

   // R10: converted pixel leaves exactly two stages after entry
   p_csc_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(in_vld, 2));

endmodule

// File: rtl/pix_fmt_conv.sv
module pix_fmt_conv
   import pfc_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_split,
   input  logic             in_valid,
   input  logic             in_sol,
   input  logic [PIX_W-1:0] in_byte,
   output logic [PIX_W-1:0] out_data,
   output logic             out_luma_vld,
   output logic             out_chroma_vld
);
   localparam int GROUP = 4;
   localparam int PH_W  = $clog2(GROUP);
   localparam int BYTE_STAGES = 3;

   if (PIX_W != 8) begin : g_bad_width
      $error("pix_fmt_conv: byte formats are defined for PIX_W == 8");
   end

   pfc_mode_e        mode;
   logic [PH_W-1:0]  phase;
   logic             is_rgb;
   pfc_rgb_t         rgb_now;

   assign mode   = pfc_mode_e'(cfg_mode);
   assign is_rgb = (mode == PFC_RGB565) || (mode == PFC_RGB444);

   pfc_byte_phase #(.GROUP(GROUP)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sol    (in_sol),
      .cur_phase (phase)
   );

   pfc_rgb_unpack #(.PIX_W(PIX_W)) u_unpack (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_we   (in_valid && is_rgb && !phase[0]),
      .in_byte (in_byte),
      .is_444  (mode == PFC_RGB444),
      .rgb     (rgb_now)
   );

   // byte classification at the input
   logic l_now, c_now;
   always_comb begin
      l_now = 1'b0;
      c_now = 1'b0;
      if (in_valid) begin
         unique case (mode)
            PFC_RAW:   l_now = 1'b1;
            PFC_YC422: begin
               l_now = !cfg_split || !phase[0];
               c_now =  cfg_split &&  phase[0];
            end
            default: ;
         endcase
      end
   end

   // stage 1 for the RGB path
   logic     s1_pix_vld, s1_cr;
   pfc_rgb_t s1_rgb;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_pix_vld <= 1'b0;
         s1_cr      <= 1'b0;
         s1_rgb     <= '0;
      end else begin
         s1_pix_vld <= in_valid && is_rgb && phase[0];
         s1_cr      <= phase[1];
         s1_rgb     <= rgb_now;
      end
   end

   logic             csc_vld;
   logic [PIX_W-1:0] csc_y, csc_c;
   pfc_csc #(.PIX_W(PIX_W)) u_csc (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (s1_pix_vld),
      .in_rgb  (s1_rgb),
      .in_cr   (s1_cr),
      .out_vld (csc_vld),
      .out_y   (csc_y),
      .out_c   (csc_c)
   );

   // byte path delay line, depth matched to the conversion path
   logic [PIX_W-1:0] bd_q [BYTE_STAGES];
   logic             bl_q [BYTE_STAGES];
   logic             bc_q [BYTE_STAGES];
   for (genvar s = 0; s < BYTE_STAGES; s++) begin : g_bstage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bd_q[s] <= '0;
            bl_q[s] <= 1'b0;
            bc_q[s] <= 1'b0;
         end else if (s == 0) begin
            bd_q[s] <= in_byte;
            bl_q[s] <= l_now;
            bc_q[s] <= c_now;
         end else begin
            bd_q[s] <= bd_q[s-1];
            bl_q[s] <= bl_q[s-1];
            bc_q[s] <= bc_q[s-1];
         end
      end
   end

   // chroma of a converted pixel waits one cycle behind its luma
   logic             cp_vld;
   logic [PIX_W-1:0] cp_data;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cp_vld  <= 1'b0;
         cp_data <= '0;
      end else begin
         cp_vld  <= csc_vld;
         cp_data <= csc_c;
      end
   end

   always_comb begin
      out_data       = '0;
      out_luma_vld   = 1'b0;
      out_chroma_vld = 1'b0;
      if (csc_vld) begin
         out_data     = csc_y;
         out_luma_vld = 1'b1;
      end else if (bl_q[BYTE_STAGES-1] || bc_q[BYTE_STAGES-1]) begin
         out_data       = bd_q[BYTE_STAGES-1];
         out_luma_vld   = bl_q[BYTE_STAGES-1];
         out_chroma_vld = bc_q[BYTE_STAGES-1];
      end else if (cp_vld) begin
         out_data       = cp_data;
         out_chroma_vld = 1'b1;
      end
   end

   // cycles since reset, for history-based checks
   logic [2:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 3'd4)  age_q <= age_q + 3'd1;
   end

   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_luma_vld, out_chroma_vld}));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 3'd4 && out_luma_vld) |-> $past(in_valid, 3));

   p_raw_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 3'd4 && $past(in_valid && mode == PFC_RAW, 3) && !$past(is_rgb, 4))
      |-> (out_luma_vld && !out_chroma_vld && out_data == $past(in_byte, 3)));

   p_chroma_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cp_vld |-> $past(csc_vld));

endmodule

// File: tb/pix_fmt_conv_tb_top.sv
module pix_fmt_conv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic       cfg_split = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sol = 1'b0;
   logic [7:0] in_byte = 8'd0;
   logic [7:0] out_data;
   logic       out_luma_vld, out_chroma_vld;

   always #(CLK_PERIOD/2) clk = ~clk;

   pix_fmt_conv #(.PIX_W(8)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_mode       (cfg_mode),
      .cfg_split      (cfg_split),
      .in_valid       (in_valid),
      .in_sol         (in_sol),
      .in_byte        (in_byte),
      .out_data       (out_data),
      .out_luma_vld   (out_luma_vld),
      .out_chroma_vld (out_chroma_vld)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   int tb_phase = 0;
   logic [7:0] tb_hi = 8'd0;
   logic       done = 1'b0;

   logic       exp_l [8];
   logic       exp_c [8];
   logic [7:0] exp_d [8];
   string      exp_t [8];

   function automatic int fit(input int x);
      return (x < 0) ? 0 : ((x > 255) ? 255 : x);
   endfunction

   function automatic int yuv(input int r, input int g, input int b, input int ch);
      int v;
      if (ch == 0)      v = ((66*r + 129*g + 25*b + 128) >>> 8) + 16;
      else if (ch == 1) v = ((-38*r - 74*g + 112*b + 128) >>> 8) + 128;
      else              v = ((112*r - 94*g - 18*b + 128) >>> 8) + 128;
      return fit(v);
   endfunction

   task automatic sched(input int when, input int d, input logic l, input logic c, input string t);
      exp_l[when % 8] = l;
      exp_c[when % 8] = c;
      exp_d[when % 8] = d[7:0];
      exp_t[when % 8] = t;
   endtask

   task automatic check_slot(input int s);
      logic bad;
      n_vec++;
      bad = (out_luma_vld !== exp_l[s]) || (out_chroma_vld !== exp_c[s]) ||
            ((exp_l[s] || exp_c[s]) && (out_data !== exp_d[s]));
      if (bad) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual l=%b c=%b d=%0d expected l=%b c=%b d=%0d",
                  exp_t[s], cyc, out_luma_vld, out_chroma_vld, out_data,
                  exp_l[s], exp_c[s], exp_d[s]);
      end
      exp_l[s] = 1'b0;
      exp_c[s] = 1'b0;
      exp_d[s] = 8'd0;
      exp_t[s] = "R11 R2";
   endtask

   // one input cycle: check the due slot, then drive and predict
   task automatic step(input logic v, input logic s, input logic [7:0] b);
      int ph, r, g, bl;
      logic [15:0] w;
      @(negedge clk);
      check_slot(cyc % 8);
      in_valid = v;
      in_sol   = s;
      in_byte  = b;
      if (v) begin
         ph = s ? 0 : tb_phase;
         tb_phase = (ph + 1) % 4;
         case (cfg_mode)
            2'b00: sched(cyc + 3, b, 1'b1, 1'b0, "R6");
            2'b01: begin
               if (!cfg_split)       sched(cyc + 3, b, 1'b1, 1'b0, "R5");
               else if (ph % 2 == 0) sched(cyc + 3, b, 1'b1, 1'b0, s ? "R4 R3" : "R3");
               else                  sched(cyc + 3, b, 1'b0, 1'b1, "R3");
            end
            default: begin
               if (ph % 2 == 0) tb_hi = b;
               else begin
                  w = {tb_hi, b};
                  if (cfg_mode == 2'b10) begin
                     r  = (int'(w[15:11]) << 3) | (int'(w[15:11]) >> 2);
                     g  = (int'(w[10:5])  << 2) | (int'(w[10:5])  >> 4);
                     bl = (int'(w[4:0])   << 3) | (int'(w[4:0])   >> 2);
                     sched(cyc + 3, yuv(r, g, bl, 0), 1'b1, 1'b0, "R7 R9");
                  end else begin
                     r  = int'(w[11:8]) * 17;
                     g  = int'(w[7:4])  * 17;
                     bl = int'(w[3:0])  * 17;
                     sched(cyc + 3, yuv(r, g, bl, 0), 1'b1, 1'b0, "R8 R9");
                  end
                  sched(cyc + 4, yuv(r, g, bl, (ph == 3) ? 2 : 1), 1'b0, 1'b1, "R10 R9");
               end
            end
         endcase
      end
      cyc++;
   endtask

   task automatic drain();
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 8'd0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         exp_l[i] = 1'b0; exp_c[i] = 1'b0; exp_d[i] = 8'd0; exp_t[i] = "R1";
      end
      // R1: quiet and zero while held in reset
      repeat (3) @(negedge clk);
      n_vec++;
      if (out_luma_vld !== 1'b0 || out_chroma_vld !== 1'b0 || out_data !== 8'd0) begin
         n_bad++;
         $display("FAIL R1 in reset: actual l=%b c=%b d=%0d expected l=0 c=0 d=0",
                  out_luma_vld, out_chroma_vld, out_data);
      end
      rst_n = 1'b1;
      step(1'b0, 1'b0, 8'd0);   // R1 slot right after release
      drain();

      // R6 raw mode
      cfg_mode = 2'b00;
      for (int i = 0; i < 256; i++) step(1'b1, (i % 64) == 0, 8'(i * 7 + 3));
      drain();

      // R3, R4 split 4:2:2 with regular lines and an early restart
      cfg_mode = 2'b01; cfg_split = 1'b1;
      for (int i = 0; i < 256; i++) step(1'b1, (i % 16) == 0, 8'(255 - i));
      step(1'b1, 1'b1, 8'h11); step(1'b1, 1'b0, 8'h22); step(1'b1, 1'b0, 8'h33);
      step(1'b0, 1'b0, 8'h00);
      for (int i = 0; i < 12; i++) step(1'b1, i == 0, 8'(8'h40 + i));
      drain();

      // R5 split disabled
      cfg_split = 1'b0;
      for (int i = 0; i < 64; i++) step(1'b1, (i % 16) == 0, 8'(i * 5));
      drain();

      // R7 every 16-bit pixel word, lines of 256 pixels
      cfg_mode = 2'b10;
      for (int p = 0; p < 65536; p++) begin
         step(1'b1, (p % 256) == 0, 8'(p >> 8));
         step(1'b1, 1'b0, 8'(p));
      end
      drain();

      // R8 every 12-bit word, junk in high nibble, stalls between bytes
      cfg_mode = 2'b11;
      for (int p = 0; p < 4096; p++) begin
         step(1'b1, (p % 64) == 0, {4'(p * 3), 4'(p >> 8)});
         if (p % 7 == 3) step(1'b0, 1'b0, 8'hA5);
         step(1'b1, 1'b0, 8'(p));
      end
      drain();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R11 watchdog: actual cycle %0d expected completion before %0d", cyc, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule